// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches an external pin next to a running counter. It records the counter value at selected pin transitions. The pin is first brought into the clock domain by a short flop chain. Transitions are then found by comparing each synchronised sample with the one before it. A mode field chooses which transitions count: rising, falling, either, or none.

There are two capture slots, and they fill in order. The first qualifying transition writes slot one and the second writes slot two. After that the slots are frozen until software re-arms the unit. Re-arming happens when software writes the capture-status clear strobe, or when the mode field moves from "none" to an edge mode. A configuration bit sets when the one-cycle capture event fires: after the first capture, or only after the second. A direction bit stops all captures while the shared pin is being driven as an output.

Top module: `tmr_capture`

## Requirements
- R1: The mode input `edge_sel_i` selects the qualifying transition: 0 means none (no capture ever), 1 means low-to-high, 2 means high-to-low, and 3 means either transition.
- R2: Captures happen only while `pin_is_input_i` is 1. A transition seen while it is 0 leaves both capture registers unchanged and raises no event.
- R3: The first qualifying transition after arming writes slot one (`cap_first_o`). The second writes slot two (`cap_second_o`). Any further transition changes neither slot until the unit is re-armed.
- R4: `cap_event_o` is a one-cycle pulse. It fires together with the first capture when `late_irq_i` is 0, or together with the second capture when `late_irq_i` is 1, and at no other time.
- R5: A cycle with `status_clr_i` high sets the fill count to zero, so the next capture goes to slot one. A transition that qualifies in that same cycle is dropped.
- R6: A change of `edge_sel_i` from 0 to a nonzero value re-arms the unit in the same way as R5. A change between two nonzero modes does not re-arm.
- R7: A pin change presented before clock edge k is stored on edge k+2. The value stored is the `count_i` present at that edge. The event pulse is visible after that same edge.
- R8: Reset clears both capture registers, the event, the fill count and the synchroniser flops to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Running counter value to be captured |
| pin_i | input | 1 | Asynchronous external pin |
| pin_is_input_i | input | 1 | 1 = pin used as input, captures allowed |
| edge_sel_i | input | 2 | Transition select: 0 none, 1 rising, 2 falling, 3 both |
| late_irq_i | input | 1 | 0 = event on first capture, 1 = event on second capture |
| status_clr_i | input | 1 | Capture-status clear strobe, re-arms the slots |
| cap_first_o | output | CNT_W | Slot one capture value |
| cap_second_o | output | CNT_W | Slot two capture value |
| cap_event_o | output | 1 | One-cycle capture event |

## Verification
A table drives every mode with both event settings. Each entry starts from a chosen pin level and applies a chosen number of toggles. This separates rising from falling selection, shows slots freezing once both are full, and tells first-capture events from second-capture events. The stored values are checked against the counter value two cycles after each pin change, which pins down the synchroniser latency. Directed runs then cover:
- transitions while the pin is an output;
- a switch between two edge modes, which must not re-arm;
- a switch from none to an edge mode, which must re-arm;
- a clear strobe landing in the same cycle as a qualifying transition.

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_i,
  input  logic             pin_is_input_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             late_irq_i,
  input  logic             status_clr_i,
  output logic [CNT_W-1:0] cap_first_o,
  output logic [CNT_W-1:0] cap_second_o,
  output logic             cap_event_o
);

  localparam logic [1:0] FULL = 2'd2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [1:0]             mode_q;
  logic [1:0]             fill_q;
  logic                   pin_s, rise, fall, hit, rearm, take;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign rise  = pin_s & ~last_q;
  assign fall  = ~pin_s & last_q;

  always_comb begin
    case (edge_sel_i)
      2'd1:    hit = rise;
      2'd2:    hit = fall;
      2'd3:    hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  assign rearm = status_clr_i | (mode_q == 2'd0 && edge_sel_i != 2'd0);
  assign take  = pin_is_input_i & hit & (fill_q != FULL) & ~rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      mode_q <= 2'd0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= pin_s;
      mode_q <= edge_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q       <= 2'd0;
      cap_first_o  <= '0;
      cap_second_o <= '0;
      cap_event_o  <= 1'b0;
    end else begin
      cap_event_o <= take & (fill_q == {1'b0, late_irq_i});
      if (rearm)
        fill_q <= 2'd0;
      else if (take) begin
        fill_q <= fill_q + 2'd1;
        if (fill_q == 2'd0) cap_first_o  <= count_i;
        else                cap_second_o <= count_i;
      end
    end
  end

  // R4
  evt_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event_o |-> (fill_q == ($past(late_irq_i) ? 2'd2 : 2'd1)));

  // R5
  clr_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_i |=> (fill_q == 2'd0 && !cap_event_o));

  // R2
  out_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input_i |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == FULL && !status_clr_i) |=> ($stable(cap_first_o) && $stable(cap_second_o)));

  // R1
  mode_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel_i == 2'd0) |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o));

  // R6
  none_to_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && edge_sel_i != 2'd0) |=> (fill_q == 2'd0));

endmodule

// File: tb/tmr_capture_bench.sv
`timescale 1ns/1ps
module tmr_capture_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         pin = 1'b0, pin_in = 1'b1, late = 1'b0, clr = 1'b0;
  logic [1:0]   sel = 2'd0;
  logic [W-1:0] cap1, cap2;
  logic         evt;

  int checks = 0, errors = 0, evt_seen = 0;

  logic [1:0]   m_mode = 2'd0;
  logic         m_late = 1'b0, lvl = 1'b0;
  int           fill_m = 0;
  logic [W-1:0] exp1 = '0, exp2 = '0;

  tmr_capture #(.CNT_W(W), .SYNC_STAGES(2)) u_tmr_capture (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .pin_i(pin),
    .pin_is_input_i(pin_in), .edge_sel_i(sel), .late_irq_i(late),
    .status_clr_i(clr), .cap_first_o(cap1), .cap_second_o(cap2),
    .cap_event_o(evt));

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;
  always @(negedge clk) if (evt) evt_seen++;

  // {mode[10:9], late[8], start[7], toggles[6:4], exp caps[3:2], exp events[1:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 3'd4, 2'd2, 2'd1},
    {2'd1, 1'b1, 1'b0, 3'd4, 2'd2, 2'd1},
    {2'd2, 1'b0, 1'b0, 3'd4, 2'd2, 2'd1},
    {2'd2, 1'b1, 1'b0, 3'd2, 2'd1, 2'd0},
    {2'd3, 1'b0, 1'b1, 3'd5, 2'd2, 2'd1},
    {2'd3, 1'b1, 1'b0, 3'd1, 2'd1, 2'd0},
    {2'd0, 1'b0, 1'b0, 3'd4, 2'd0, 2'd0},
    {2'd1, 1'b1, 1'b1, 3'd3, 2'd1, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    sel = m;
    if (m_mode == 2'd0 && m != 2'd0) fill_m = 0;
    m_mode = m;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    fill_m = 0;
  endtask

  task automatic toggle(output bit took);
    logic [W-1:0] v;
    bit qual, ev;
    lvl = ~lvl;
    v = cnt;
    pin = lvl;
    qual = pin_in && ((m_mode == 2'd1 && lvl) || (m_mode == 2'd2 && !lvl) || m_mode == 2'd3);
    took = qual && fill_m < 2;
    ev = took && (fill_m == int'(m_late));
    if (took) begin
      if (fill_m == 0) exp1 = v + 2; else exp2 = v + 2;
      fill_m++;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cap1 == exp1, "R3/R7 slot one", cap1, exp1);
    chk(cap2 == exp2, "R3/R7 slot two", cap2, exp2);
    chk(evt == ev, "R4 event timing", W'(evt), W'(ev));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit t;
    int caps, ev0;
    repeat (3) @(negedge clk);
    chk(cap1 == 0 && cap2 == 0, "R8 reset captures", cap1 | cap2, 0);
    chk(evt == 0, "R8 reset event", W'(evt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap1 == 0 && cap2 == 0 && evt == 0, "R8 after release", cap1 | cap2, 0);

    for (int i = 0; i < 8; i++) begin
      set_mode(2'd0);
      lvl = VEC[i][7];
      pin = lvl;
      late = VEC[i][8];
      m_late = late;
      repeat (5) @(negedge clk);
      pulse_clr();
      set_mode(VEC[i][10:9]);
      caps = 0;
      ev0 = evt_seen;
      for (int k = 0; k < int'(VEC[i][6:4]); k++) begin
        toggle(t);
        if (t) caps++;
      end
      chk(caps == int'(VEC[i][3:2]), "R1/R3 capture count", W'(caps), W'(VEC[i][3:2]));
      chk(evt_seen - ev0 == int'(VEC[i][1:0]), "R4 event count", W'(evt_seen - ev0), W'(VEC[i][1:0]));
    end

    // R2: pin used as output, transitions ignored
    set_mode(2'd0);
    late = 1'b0; m_late = 1'b0;
    set_mode(2'd3);
    pin_in = 1'b0;
    ev0 = evt_seen;
    toggle(t);
    toggle(t);
    chk(evt_seen == ev0, "R2 no event while output", W'(evt_seen - ev0), 0);
    pin_in = 1'b1;
    toggle(t);
    chk(t && fill_m == 1, "R2 first capture after input restored", W'(fill_m), 1);

    // R6: change between edge modes keeps slots frozen; none->edge re-arms
    toggle(t);
    set_mode(2'd1);
    toggle(t);
    toggle(t);
    chk(fill_m == 2, "R6 no re-arm between edge modes", W'(fill_m), 2);
    set_mode(2'd0);
    set_mode(2'd1);
    if (lvl) toggle(t);
    ev0 = evt_seen;
    toggle(t);
    chk(t, "R6 re-armed capture into slot one", W'(t), 1);
    chk(evt_seen - ev0 == 1, "R6 event after re-arm", W'(evt_seen - ev0), 1);

    // R5: clear re-arms after full
    toggle(t); toggle(t);
    pulse_clr();
    if (lvl) toggle(t);
    toggle(t);
    chk(t, "R5 capture after clear", W'(t), 1);

    // R5: clear in the same cycle as a qualifying transition wins
    pulse_clr();
    if (lvl) toggle(t);
    lvl = 1'b1;
    pin = 1'b1;
    ev0 = evt_seen;
    repeat (2) @(posedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    fill_m = 0;
    repeat (2) @(negedge clk);
    chk(cap1 == exp1, "R5 dropped edge slot one", cap1, exp1);
    chk(cap2 == exp2, "R5 dropped edge slot two", cap2, exp2);
    chk(evt_seen == ev0, "R5 dropped edge no event", W'(evt_seen - ev0), 0);
    toggle(t);
    toggle(t);
    chk(t && fill_m == 1, "R5 next capture lands in slot one", W'(fill_m), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule